// File: doc/BRIEF.md
# SPI Target with Select Gating

This block is the receiving end of a four-wire SPI link. It runs entirely on the system clock: the incoming serial clock, the active-low select and the serial data input are each passed through a short flip-flop chain into that domain. Edges of the serial clock are found there by comparing consecutive samples. While selected, the block assembles one byte per eight sampling edges, most significant bit first. At the same time it shifts out a byte that was preloaded from a transmit holding register.

A small register port lets a processor use the block. The port writes the byte to send, reads the byte received, reads a status word and sets the clock polarity and phase. Two flags are also brought out as pins: one says a received byte is waiting, and one says a byte arrived before the previous one was collected. The serial output comes with an output-enable. A pad cell uses the enable to float the line whenever the block is not selected. The block does not generate a serial clock and does not detect select conflicts.

Top module: `spi_target`

## Requirements
- R1: After reset, `rx_full`, `rx_ovf` and `miso_oe` are 0. The status word (address 1) reads 0x04 (transmit-empty set), and the control word (address 2) reads 0x00.
- R2: Serial clock edges that occur while `ss_n_in` is high are ignored: they shift nothing and complete no byte.
- R3: After eight sampling edges within one selection, the byte is copied into the receive register and `rx_full` is set. The byte is read at address 0 and is assembled most significant bit first. `rx_full` is also status bit 0.
- R4: Control word bit 0 is the clock phase and bit 1 is the idle clock level. With phase 0, data is sampled on the leading edge (the edge leaving the idle level); with phase 1, on the trailing edge. `miso_out` presents the preloaded byte most significant bit first. Its first bit is present before the first clock edge after select falls, and the output advances on each trailing edge.
- R5: All four polarity/phase combinations exchange bytes correctly in both directions.
- R6: A write to address 0 sets the byte for the next transfer and clears status bit 2 (transmit-empty). The byte is taken into the output shifter when select falls, or when a byte ends while select stays low; that load sets bit 2 again. If no new write occurred, the previous byte is sent again.
- R7: If a byte completes while `rx_full` is set and no clearing read occurs in that cycle, `rx_ovf` (status bit 1) is set and the receive register keeps the unread byte.
- R8: A status read taken while `rx_full` is set, followed by a data read, clears both `rx_full` and `rx_ovf`. A data read without that prior status read clears nothing.
- R9: If select rises before a byte is complete, the partial bits are discarded, nothing is transferred, and the next selection starts counting from bit zero.
- R10: `miso_oe` is 0 while select is high and 1 while select is low, measured after the synchronizer delay.
- R11: If a clearing data read falls in the same cycle as a byte completion, the read returns the old byte. The new byte is then stored, `rx_full` stays 1 and `rx_ovf` stays 0.
- R12: Any serial clock whose levels each last at least four system clock cycles is handled. No rate setting exists or is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Serial clock from the master (asynchronous) |
| ss_n_in | input | 1 | Active-low select (asynchronous) |
| mosi_in | input | 1 | Serial data from the master (asynchronous) |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the serial data pad |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| rx_full | output | 1 | A received byte is waiting |
| rx_ovf | output | 1 | A byte arrived before the previous one was collected |

## Verification
A byte can complete in the same cycle that the processor issues the data read meant to clear the previous byte. The two must not be read as an overrun, and the new byte must not be lost. The bench arms the clear with a status read. During the next transfer it then times a data read to the exact cycle the last sampling edge reaches the receive logic, which is three system cycles after that edge is driven. It judges the outcome on the returned value (the old byte), on the flags (still full, no overrun) and on the next clearing read (the new byte).

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned ADDR_W  = 2;

    // status word bit positions
    localparam int unsigned ST_FULL = 0;
    localparam int unsigned ST_OVF  = 1;
    localparam int unsigned ST_TXE  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_CTRL = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // bit 1 = idle clock level, bit 0 = phase
    typedef struct packed {
        logic cpol;
        logic cpha;
    } clk_mode_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edges_t;

    typedef struct packed {
        logic sample;
        logic launch;
    } bit_events_t;

    // Map raw clock edges onto sampling and launching events for a mode.
    function automatic bit_events_t decode_edges(clk_mode_t m, sck_edges_t e);
        bit_events_t ev;
        logic leading;
        logic trailing;
        leading   = m.cpol ? e.fall : e.rise;
        trailing  = m.cpol ? e.rise : e.fall;
        ev.sample = m.cpha ? trailing : leading;
        ev.launch = trailing;
        return ev;
    endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int unsigned N_SIG   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [N_SIG-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SIG-1:0] din,
    output logic [N_SIG-1:0] dout
);

    for (genvar g = 0; g < N_SIG; g++) begin : g_chain
        logic [STAGES-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= {STAGES{RST_VAL[g]}};
            end else begin
                q <= {q[STAGES-2:0], din[g]};
            end
        end
        assign dout[g] = q[STAGES-1];
    end

endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter
    import spi_tgt_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sck_s,
    input  logic         ss_n_s,
    input  logic         mosi_s,
    input  clk_mode_t    mode,
    input  logic [W-1:0] tx_hold,
    output logic         tx_load,
    output logic         rx_done,
    output logic [W-1:0] rx_byte,
    output logic         miso_bit,
    output logic         miso_oe
);

    localparam int unsigned CNT_W = (W > 2) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic             sck_q;
    logic             ss_n_q;
    logic [CNT_W-1:0] in_cnt;
    logic [CNT_W-1:0] out_cnt;
    logic [W-1:0]     rx_sh;
    logic [W-1:0]     tx_sh;

    sck_edges_t  edges;
    bit_events_t ev;
    logic        selected;
    logic        start;
    logic        sample_en;
    logic        launch_en;

    always_comb begin
        edges.rise = sck_s & ~sck_q;
        edges.fall = ~sck_s & sck_q;
        ev         = decode_edges(mode, edges);
        selected   = ~ss_n_s;
        start      = ss_n_q & ~ss_n_s;
        sample_en  = ev.sample & selected & ~start;
        launch_en  = ev.launch & selected & ~start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            ss_n_q  <= 1'b1;
            in_cnt  <= '0;
            out_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else begin
            sck_q  <= sck_s;
            ss_n_q <= ss_n_s;
            if (!selected) begin
                in_cnt  <= '0;
                out_cnt <= '0;
            end else if (start) begin
                tx_sh   <= tx_hold;
                in_cnt  <= '0;
                out_cnt <= '0;
            end else begin
                if (sample_en) begin
                    rx_sh  <= {rx_sh[W-2:0], mosi_s};
                    in_cnt <= (in_cnt == LAST) ? '0 : in_cnt + 1'b1;
                end
                if (launch_en) begin
                    if (out_cnt == LAST) begin
                        tx_sh   <= tx_hold;
                        out_cnt <= '0;
                    end else begin
                        tx_sh   <= {tx_sh[W-2:0], 1'b0};
                        out_cnt <= out_cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign rx_done  = sample_en & (in_cnt == LAST);
    assign rx_byte  = {rx_sh[W-2:0], mosi_s};
    assign tx_load  = start | (launch_en & (out_cnt == LAST));
    assign miso_bit = tx_sh[W-1];
    assign miso_oe  = selected;

    AST_DONE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> !ss_n_s) else $error("byte completed while deselected"); // R2

    AST_DESELECT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        ss_n_s |=> (in_cnt == '0 && out_cnt == '0)) else $error("count survived deselect"); // R9

endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs
    import spi_tgt_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output clk_mode_t         mode,
    output logic [W-1:0]      tx_hold,
    input  logic              tx_load,
    input  logic              rx_done,
    input  logic [W-1:0]      rx_byte,
    output logic              rx_full,
    output logic              rx_ovf
);

    reg_sel_e     sel;
    logic         wr_data;
    logic         wr_ctrl;
    logic         rd_data;
    logic         rd_stat;
    logic         clear_now;
    logic         armed;
    logic         tx_empty;
    logic [W-1:0] rx_data;

    always_comb begin
        sel       = reg_sel_e'(bus_addr);
        wr_data   = bus_wr && (sel == REG_DATA);
        wr_ctrl   = bus_wr && (sel == REG_CTRL);
        rd_data   = bus_rd && (sel == REG_DATA);
        rd_stat   = bus_rd && (sel == REG_STAT);
        clear_now = rd_data && armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            tx_hold  <= '0;
            tx_empty <= 1'b1;
        end else begin
            if (wr_ctrl) begin
                mode <= clk_mode_t'(bus_wdata[1:0]);
            end
            if (wr_data) begin
                tx_hold  <= bus_wdata;
                tx_empty <= 1'b0;
            end else if (tx_load) begin
                tx_empty <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            rx_ovf  <= 1'b0;
            armed   <= 1'b0;
        end else begin
            if (rx_done) begin
                if (!rx_full || clear_now) begin
                    rx_data <= rx_byte;
                    rx_full <= 1'b1;
                    rx_ovf  <= 1'b0;
                end else begin
                    rx_ovf  <= 1'b1;
                end
            end else if (clear_now) begin
                rx_full <= 1'b0;
                rx_ovf  <= 1'b0;
            end
            if (rd_stat) begin
                armed <= rx_full;
            end else if (rd_data) begin
                armed <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_DATA: bus_rdata = rx_data;
            REG_STAT: begin
                bus_rdata[ST_FULL] = rx_full;
                bus_rdata[ST_OVF]  = rx_ovf;
                bus_rdata[ST_TXE]  = tx_empty;
            end
            REG_CTRL: bus_rdata[1:0] = mode;
            REG_NONE: bus_rdata = '0;
        endcase
    end

    AST_FULL_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> rx_full) else $error("byte done but not full"); // R3

    AST_NO_OVERFLOW_WITHOUT_FULL: assert property (@(posedge clk) disable iff (rst)
        rx_ovf |-> rx_full) else $error("overflow without pending byte"); // R7

    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_full && !clear_now) |=> $stable(rx_data)) else $error("unread byte overwritten"); // R7

    AST_CLEAR_NEEDS_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_full) |-> $past(rd_data && armed)) else $error("full cleared without status+data read"); // R8

    AST_COLLIDE_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
        (rx_done && clear_now) |=> (rx_full && !rx_ovf)) else $error("collision mishandled"); // R11

endmodule

// File: rtl/spi_target.sv
module spi_target
    import spi_tgt_pkg::*;
#(
    parameter int unsigned DATA_W      = BYTE_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_in,
    input  logic              ss_n_in,
    input  logic              mosi_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rx_full,
    output logic              rx_ovf
);

    localparam int unsigned N_SIG = 3;
    // index 0 = clock, 1 = select, 2 = data; select idles high
    localparam logic [N_SIG-1:0] SYNC_RST = 3'b010;

    logic [N_SIG-1:0]  pins_s;
    clk_mode_t         mode;
    logic [DATA_W-1:0] tx_hold;
    logic              tx_load;
    logic              rx_done;
    logic [DATA_W-1:0] rx_byte;

    spi_tgt_sync #(
        .N_SIG   (N_SIG),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({mosi_in, ss_n_in, sck_in}),
        .dout (pins_s)
    );

    spi_tgt_shifter #(
        .W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (pins_s[0]),
        .ss_n_s   (pins_s[1]),
        .mosi_s   (pins_s[2]),
        .mode     (mode),
        .tx_hold  (tx_hold),
        .tx_load  (tx_load),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte),
        .miso_bit (miso_out),
        .miso_oe  (miso_oe)
    );

    spi_tgt_regs #(
        .W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mode      (mode),
        .tx_hold   (tx_hold),
        .tx_load   (tx_load),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .rx_full   (rx_full),
        .rx_ovf    (rx_ovf)
    );

    AST_OE_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_s[1]) |-> !miso_oe) else $error("output enabled while deselected"); // R10

endmodule

// File: tb/sim_spi_target.sv
`timescale 1ns/1ps
module sim_spi_target;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck_in = 1'b0;
    logic       ss_n_in = 1'b1;
    logic       mosi_in = 1'b0;
    logic       miso_out;
    logic       miso_oe;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rx_full;
    logic       rx_ovf;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  cpol = 1'b0;
    bit  cpha = 1'b0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_target u0 (
        .clk       (clk),
        .rst       (rst),
        .sck_in    (sck_in),
        .ss_n_in   (ss_n_in),
        .mosi_in   (mosi_in),
        .miso_out  (miso_out),
        .miso_oe   (miso_oe),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_full   (rx_full),
        .rx_ovf    (rx_ovf)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_mode(input bit pol, input bit pha);
        cpol = pol; cpha = pha;
        bus_write(2'd2, {6'd0, pol, pha});
        sck_in = pol;
        wait_neg(4);
    endtask

    // master side: nbits bits, half = cycles per clock level
    task automatic xfer(input logic [7:0] mo, input int half, input int nbits,
                        input bit rd_at_end, output logic [7:0] mi, output logic [7:0] rd_val);
        mi = 8'h00; rd_val = 8'h00;
        ss_n_in = 1'b0;
        wait_neg(6);
        for (int i = 7; i >= 8 - nbits; i--) begin
            if (!cpha) begin
                mosi_in = mo[i];
                wait_neg(half);
                mi[i] = miso_out;
                sck_in = ~cpol;
                if (i == 0 && rd_at_end) begin
                    wait_neg(2);
                    bus_read(2'd0, rd_val);
                    wait_neg(half - 3);
                end else begin
                    wait_neg(half);
                end
                sck_in = cpol;
            end else begin
                wait_neg(half);
                sck_in = ~cpol;
                mosi_in = mo[i];
                wait_neg(half);
                mi[i] = miso_out;
                sck_in = cpol;
                if (i == 0 && rd_at_end) begin
                    wait_neg(2);
                    bus_read(2'd0, rd_val);
                end
            end
        end
        wait_neg(half);
        ss_n_in = 1'b1;
        wait_neg(6);
    endtask

    task automatic clear_rx(output logic [7:0] d);
        logic [7:0] s;
        bus_read(2'd1, s);
        bus_read(2'd0, d);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1", "rx_full", rx_full, 0);
        chk("R1", "rx_ovf", rx_ovf, 0);
        chk("R1", "miso_oe", miso_oe, 0);
        bus_read(2'd1, d); chk("R1", "status", d, 8'h04);
        bus_read(2'd2, d); chk("R1", "control", d, 8'h00);
    endtask

    task automatic t_basic;
        logic [7:0] mi, rv, d;
        set_mode(0, 0);
        bus_write(2'd0, 8'hA5);
        bus_read(2'd1, d); chk("R6", "txe clear after write", d[2], 0);
        xfer(8'h3C, 4, 8, 0, mi, rv);
        chk("R4", "master received", mi, 8'hA5);
        chk("R3", "rx_full set", rx_full, 1);
        bus_read(2'd1, d);
        chk("R6", "txe set after load", d[2], 1);
        chk("R3", "status full bit", d[0], 1);
        bus_read(2'd0, d);
        chk("R3", "received byte", d, 8'h3C);
        chk("R8", "full cleared", rx_full, 0);
    endtask

    task automatic t_modes;
        logic [7:0] mi, rv, d;
        logic [7:0] txp [4] = '{8'h81, 8'h6E, 8'hF0, 8'h1D};
        logic [7:0] rxp [4] = '{8'h7E, 8'hB2, 8'h0F, 8'hC9};
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            bus_read(2'd2, d); chk("R4", "control readback", d, {6'd0, m[1], m[0]});
            bus_write(2'd0, txp[m]);
            xfer(rxp[m], 4, 8, 0, mi, rv);
            chk("R5", "miso byte", mi, txp[m]);
            clear_rx(d);
            chk("R5", "mosi byte", d, rxp[m]);
        end
    endtask

    task automatic t_resend;
        logic [7:0] mi, rv, d;
        set_mode(0, 1);
        bus_write(2'd0, 8'h5A);
        xfer(8'h01, 4, 8, 0, mi, rv);
        chk("R6", "first send", mi, 8'h5A);
        clear_rx(d);
        xfer(8'h02, 4, 8, 0, mi, rv);
        chk("R6", "resend without write", mi, 8'h5A);
        clear_rx(d);
    endtask

    task automatic t_deselected;
        logic [7:0] mi, rv, d;
        set_mode(0, 0);
        mosi_in = 1'b1;
        for (int k = 0; k < 8; k++) begin
            sck_in = 1'b1; wait_neg(4);
            sck_in = 1'b0; wait_neg(4);
        end
        chk("R2", "no byte while deselected", rx_full, 0);
        chk("R10", "oe low while deselected", miso_oe, 0);
        ss_n_in = 1'b0; wait_neg(6);
        chk("R10", "oe high while selected", miso_oe, 1);
        ss_n_in = 1'b1; wait_neg(6);
        chk("R10", "oe low after deselect", miso_oe, 0);
        bus_write(2'd0, 8'h00);
        xfer(8'h69, 4, 8, 0, mi, rv);
        clear_rx(d);
        chk("R2", "byte after ignored clocks", d, 8'h69);
    endtask

    task automatic t_abort;
        logic [7:0] mi, rv, d;
        set_mode(1, 0);
        xfer(8'hFF, 4, 4, 0, mi, rv);
        chk("R9", "partial byte not stored", rx_full, 0);
        xfer(8'h96, 4, 8, 0, mi, rv);
        chk("R9", "full after restart", rx_full, 1);
        clear_rx(d);
        chk("R9", "byte after abort", d, 8'h96);
    endtask

    task automatic t_overflow;
        logic [7:0] mi, rv, d;
        set_mode(0, 0);
        xfer(8'h11, 4, 8, 0, mi, rv);
        chk("R7", "no overflow yet", rx_ovf, 0);
        xfer(8'h22, 4, 8, 0, mi, rv);
        chk("R7", "overflow pin", rx_ovf, 1);
        bus_read(2'd1, d); chk("R7", "status ovf bit", d[1], 1);
        bus_read(2'd0, d); chk("R7", "unread byte kept", d, 8'h11);
        chk("R8", "ovf cleared", rx_ovf, 0);
        chk("R8", "full cleared", rx_full, 0);
    endtask

    task automatic t_read_no_arm;
        logic [7:0] mi, rv, d;
        xfer(8'h33, 4, 8, 0, mi, rv);
        bus_read(2'd0, d);
        chk("R8", "data read alone", d, 8'h33);
        chk("R8", "full kept without status read", rx_full, 1);
        clear_rx(d);
        chk("R8", "full cleared by sequence", rx_full, 0);
    endtask

    task automatic t_collide;
        logic [7:0] mi, rv, d;
        set_mode(0, 0);
        xfer(8'h44, 4, 8, 0, mi, rv);
        bus_read(2'd1, d);
        xfer(8'h55, 4, 8, 1, mi, rv);
        chk("R11", "read returns old byte", rv, 8'h44);
        chk("R11", "full stays set", rx_full, 1);
        chk("R11", "no overflow", rx_ovf, 0);
        clear_rx(d);
        chk("R11", "new byte kept", d, 8'h55);
    endtask

    task automatic t_rates;
        logic [7:0] mi, rv, d;
        set_mode(1, 1);
        bus_write(2'd0, 8'h3E);
        xfer(8'hC3, 8, 8, 0, mi, rv);
        chk("R12", "slow clock miso", mi, 8'h3E);
        clear_rx(d);
        chk("R12", "slow clock mosi", d, 8'hC3);
        bus_write(2'd0, 8'hD4);
        xfer(8'h4B, 4, 8, 0, mi, rv);
        chk("R12", "fast clock miso", mi, 8'hD4);
        clear_rx(d);
        chk("R12", "fast clock mosi", d, 8'h4B);
    endtask

    initial begin
        wait_neg(5);
        rst = 1'b0;
        wait_neg(2);
        t_reset();
        t_basic();
        t_modes();
        t_resend();
        t_deselected();
        t_abort();
        t_overflow();
        t_read_no_arm();
        t_collide();
        t_rates();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule